// File: doc/BRIEF.md
# Card Presence and Fault Interrupt Controller

This block drives the active-low interrupt line of a smart-card interface. Its meaning depends on whether a card session is open. With no session open, the line reports only whether a card is seated, and the fault flags have no effect. With a session open, the line drops when the card is pulled out or when any fault flag rises. It then stays low for the rest of that session.

In the same cycle that the line drops inside a session, the block sends a one-cycle start pulse to the deactivation sequencer. It sends at most one such pulse per session. The session command input is active low. The card-presence input is assumed to be already debounced. The number of fault flags is a parameter. Both outputs are registered, so each one follows its inputs by exactly one clock.

Top module: `card_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_n` and `deact_start` are 0 after that edge. Inside a session, `irq_n` then stays high until a trip condition appears.
- R2: With `session_n` high (no session), `irq_n` after a clock edge equals `card_present` sampled at that edge: 0 means no card, 1 means card present.
- R3: With `session_n` high, no value of `fault_flags` changes `irq_n`.
- R4: With `session_n` high at a clock edge, `deact_start` is 0 after that edge.
- R5: With `session_n` low, if `card_present` is 0 at an edge, `irq_n` is 0 after that edge.
- R6: With `session_n` low, if any single bit of `fault_flags` is 1 at an edge, `irq_n` is 0 after that edge. Every bit position has the same effect.
- R7: Inside a session, `deact_start` is 1 in exactly the cycle in which `irq_n` first goes low.
- R8: `deact_start` is a one-cycle pulse. It occurs at most once per session, even if the card or the faults keep changing after the trip.
- R9: Once `irq_n` is low inside a session, it stays low until `session_n` is high at an edge. This holds even if the faults clear or the card is seated again.
- R10: If a fault is already present in the first cycle that `session_n` is low, `irq_n` is 0 and `deact_start` is 1 after that edge.
- R11: After a session ends, `irq_n` again follows `card_present` one edge later. A new session can trip and pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| session_n | input | 1 | Session command: 0 means a session is active |
| card_present | input | 1 | Debounced presence: 1 means a card is seated |
| fault_flags | input | NUM_FAULTS | One bit per fault source, 1 means fault |
| irq_n | output | 1 | Active-low interrupt line |
| deact_start | output | 1 | One-cycle deactivation start request |

## Verification
Both results are due exactly one rising edge after the inputs that cause them. No path through the block is combinational. The bench changes inputs on the falling edge, waits for the next rising edge, and samples 1 ns later. So every check reads the value caused by the inputs it just applied. Single-pulse and latching behaviour are checked by stepping several more edges with changing stimulus and sampling after each one.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;

  // Any one of the fault bits, or a missing card, is a reason to trip.
  function automatic logic trip_cause(input logic present, input logic fault_any);
    return (~present) | fault_any;
  endfunction

  // Level of the interrupt line that goes with the session state and the trip state.
  function automatic logic line_level(input logic no_session, input logic present,
                                      input logic tripped);
    return no_session ? present : ~tripped;
  endfunction

endpackage

// File: rtl/cif_fault_merge.sv
module cif_fault_merge #(
  parameter int NUM_FAULTS = 3
) (
  input  logic [NUM_FAULTS-1:0] fault_flags,
  output logic                  fault_any
);
  logic [NUM_FAULTS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_or
    assign chain[g+1] = chain[g] | fault_flags[g];
  end

  assign fault_any = chain[NUM_FAULTS];
endmodule

// File: rtl/cif_session_latch.sv
module cif_session_latch (
  input  logic clk,
  input  logic rst,
  input  logic session_n,
  input  logic trip_req,
  output logic tripped_q,
  output logic trip_event,
  output logic deact_start
);
  // A new trip: inside a session, a cause is present, and the session has not tripped yet.
  assign trip_event = ~session_n & trip_req & ~tripped_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped_q   <= 1'b0;
      deact_start <= 1'b0;
    end else begin
      tripped_q   <= session_n ? 1'b0 : (tripped_q | trip_req);
      deact_start <= trip_event;
    end
  end

  a_r4_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    session_n |=> !deact_start);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    deact_start |=> !deact_start);
  a_r8_once_per_session: assert property (@(posedge clk) disable iff (rst)
    (tripped_q && !session_n) |=> !deact_start);
endmodule

// File: rtl/cif_irq_drive.sv
module cif_irq_drive
  import card_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic session_n,
  input  logic card_present,
  input  logic trip_req,
  input  logic tripped_q,
  output logic irq_n
);
  logic tripped_next;
  assign tripped_next = ~session_n & (tripped_q | trip_req);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b0;
    else     irq_n <= line_level(session_n, card_present, tripped_next);
  end

  a_r2_idle_follows_presence: assert property (@(posedge clk) disable iff (rst)
    session_n |=> (irq_n == $past(card_present)));
  a_r5_removal_drops: assert property (@(posedge clk) disable iff (rst)
    (!session_n && !card_present) |=> !irq_n);
  a_r9_latched_low: assert property (@(posedge clk) disable iff (rst)
    (!session_n && tripped_q) |=> !irq_n);
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
#(
  parameter int NUM_FAULTS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  session_n,
  input  logic                  card_present,
  input  logic [NUM_FAULTS-1:0] fault_flags,
  output logic                  irq_n,
  output logic                  deact_start
);
  logic fault_any;
  logic trip_req;
  logic tripped_q;
  logic trip_event;

  cif_fault_merge #(.NUM_FAULTS(NUM_FAULTS)) u_merge (
    .fault_flags (fault_flags),
    .fault_any   (fault_any)
  );

  assign trip_req = trip_cause(card_present, fault_any);

  cif_session_latch u_latch (
    .clk         (clk),
    .rst         (rst),
    .session_n   (session_n),
    .trip_req    (trip_req),
    .tripped_q   (tripped_q),
    .trip_event  (trip_event),
    .deact_start (deact_start)
  );

  cif_irq_drive u_drive (
    .clk          (clk),
    .rst          (rst),
    .session_n    (session_n),
    .card_present (card_present),
    .trip_req     (trip_req),
    .tripped_q    (tripped_q),
    .irq_n        (irq_n)
  );

  a_r6_fault_drops: assert property (@(posedge clk) disable iff (rst)
    (!session_n && fault_any) |=> !irq_n);
  a_r7_pulse_with_fall: assert property (@(posedge clk) disable iff (rst)
    trip_event |=> (deact_start && !irq_n));
  a_r7_pulse_means_low: assert property (@(posedge clk) disable iff (rst)
    deact_start |-> !irq_n);
endmodule

// File: tb/test_card_irq_ctrl.sv
`timescale 1ns/1ps
module test_card_irq_ctrl;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          session_n;
  logic          card_present;
  logic [NF-1:0] fault_flags;
  logic          irq_n;
  logic          deact_start;
  int            errors = 0;
  int            checks = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  card_irq_ctrl #(.NUM_FAULTS(NF)) i_card_irq_ctrl (
    .clk(clk), .rst(rst), .session_n(session_n), .card_present(card_present),
    .fault_flags(fault_flags), .irq_n(irq_n), .deact_start(deact_start)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic sn, input logic pres, input logic [NF-1:0] f);
    @(negedge clk);
    session_n = sn; card_present = pres; fault_flags = f;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst = 1'b1; session_n = 1'b1; card_present = 1'b1; fault_flags = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_n in reset", irq_n, 1'b0);
    chk("R1 deact in reset", deact_start, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R2 presence after reset", irq_n, 1'b1);
  endtask

  task automatic t_idle_presence;
    drive(1'b1, 1'b0, '0);
    chk("R2 no card", irq_n, 1'b0);
    chk("R4 no pulse idle", deact_start, 1'b0);
    drive(1'b1, 1'b1, '0);
    chk("R2 card seated", irq_n, 1'b1);
  endtask

  task automatic t_idle_faults_ignored;
    for (int v = 1; v < (1 << NF); v++) begin
      drive(1'b1, 1'b1, NF'(v));
      chk("R3 fault ignored idle", irq_n, 1'b1);
      chk("R4 no pulse idle fault", deact_start, 1'b0);
    end
    drive(1'b1, 1'b0, '1);
    chk("R3 absent card idle with faults", irq_n, 1'b0);
    drive(1'b1, 1'b1, '0);
  endtask

  task automatic t_card_removed;
    drive(1'b0, 1'b1, '0);
    chk("R1 session open no trip", irq_n, 1'b1);
    chk("R7 no pulse without trip", deact_start, 1'b0);
    drive(1'b0, 1'b0, '0);
    chk("R5 removal drops", irq_n, 1'b0);
    chk("R7 pulse with fall", deact_start, 1'b1);
    drive(1'b0, 1'b1, '0);
    chk("R9 reinsertion keeps low", irq_n, 1'b0);
    chk("R8 pulse one cycle", deact_start, 1'b0);
    drive(1'b1, 1'b1, '0);
    chk("R11 session end restores", irq_n, 1'b1);
  endtask

  task automatic t_each_fault;
    for (int b = 0; b < NF; b++) begin
      drive(1'b0, 1'b1, '0);
      chk("R6 session clean", irq_n, 1'b1);
      drive(1'b0, 1'b1, NF'(1) << b);
      chk("R6 fault bit drops", irq_n, 1'b0);
      chk("R7 fault bit pulse", deact_start, 1'b1);
      drive(1'b1, 1'b1, '0);
      chk("R11 idle again", irq_n, 1'b1);
    end
  endtask

  task automatic t_latch_hold;
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b1, NF'(2));
    chk("R6 trip", irq_n, 1'b0);
    chk("R7 trip pulse", deact_start, 1'b1);
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, k[0], (k[1] ? NF'(1) : '0));
      chk("R9 stays low", irq_n, 1'b0);
      chk("R8 no second pulse", deact_start, 1'b0);
    end
    drive(1'b1, 1'b0, '0);
    chk("R11 idle reports absent", irq_n, 1'b0);
    drive(1'b1, 1'b1, '0);
    chk("R11 idle reports present", irq_n, 1'b1);
  endtask

  task automatic t_fault_at_start;
    drive(1'b1, 1'b1, NF'(4));
    chk("R3 pending fault idle", irq_n, 1'b1);
    drive(1'b0, 1'b1, NF'(4));
    chk("R10 start fault drops", irq_n, 1'b0);
    chk("R10 start fault pulse", deact_start, 1'b1);
    drive(1'b0, 1'b1, NF'(4));
    chk("R8 start pulse single", deact_start, 1'b0);
    drive(1'b1, 1'b1, '0);
    drive(1'b0, 1'b1, '0);
    chk("R11 new session clean", irq_n, 1'b1);
    drive(1'b0, 1'b0, '0);
    chk("R11 rearmed pulse", deact_start, 1'b1);
    drive(1'b1, 1'b1, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_presence();
    t_idle_faults_ignored();
    t_card_removed();
    t_each_fault();
    t_latch_hold();
    t_fault_at_start();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule